// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block gives a host bus three independent 16-bit down counters. Each counter has its own data port at addresses 0, 1 and 2. All three share a control port at address 3. A control byte written to the shared port names one channel and does one of two things. It either sets that channel's counting mode, byte access order and number base, or it freezes a snapshot of the channel's running count so that software can read it while counting continues.

Counting advances only on clock cycles where the shared count enable is high. Each channel has a gate input and a timer output. The gate either suspends counting or, in the hardware-strobe mode, starts a run on its rising edge. The output forms terminal-count flags, periodic pulses, square waves or single strobes. Loading a count of zero selects the largest period the number base allows.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every channel output is high and the read data bus is 0.
- R2: In a control byte, bits 7:6 pick channel 0, 1 or 2. The value 3 in bits 7:6 is ignored, and no channel output changes.
- R3: Control bits 5:4 set the byte access: 1 is low byte only, 2 is high byte only, 3 is low byte then high byte. In every case the other byte of the count is zero, and a new count starts only once its final byte has been written.
- R4: Control bits 5:4 = 0 freeze a snapshot of the channel's count. The snapshot is held until it has been read out completely, and further freeze commands in that time are ignored. Counting, mode and output are not affected.
- R5: When no snapshot is held, a read returns the live count. In low-then-high access, successive reads return the low byte and then the high byte.
- R6: Control bit 0 = 1 selects four-digit BCD counting. A loaded count of 0 first decrements to 9999 in BCD and to FFFF in binary.
- R7: Mode 0 (bits 3:1 = 0): the output is low from the control write until N count ticks after the load, then stays high.
- R8: Mode 2: the output is low for exactly the tick period after the (N-1)th tick of each N-tick cycle, and the count reloads.
- R9: Mode 3: within each N-tick cycle the output is high for ceil(N/2) tick periods and low for floor(N/2).
- R10: Mode 4: the output is low for exactly one tick period, starting N ticks after the load, and is high otherwise.
- R11: Mode 5: a load does not start counting. A rising gate edge restarts the count, and the output strobes low for one tick period N ticks later.
- R12: Outside mode 5, a low gate holds the count unchanged.
- R13: The count changes only on clock edges where the count enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Block select for bus accesses |
| bus_addr | input | 2 | 0-2 channel data ports, 3 control port |
| bus_rd | input | 1 | Read strobe, one byte per cycle held |
| bus_wr | input | 1 | Write strobe, one byte per cycle held |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data, 0 when not reading a channel |
| cnt_tick | input | 1 | Count enable shared by all channels |
| ch_gate | input | 3 | Per-channel gate |
| ch_out | output | 3 | Per-channel timer output |

## Verification
The assertions assume the following about the inputs. Read and write strobes are never high in the same cycle. Every count loaded in BCD mode has digits of 9 or less. Counts loaded for mode 2 are at least 2. The snapshot, BCD-digit and single-low-pulse properties depend on these points. The stimulus writes only valid BCD values, sweeps the rate-mode period from 2 upward, and drives each bus operation as a one-cycle strobe with the other strobe held low.

// File: rtl/itm_pkg.sv
package itm_pkg;
    localparam int NCH    = 3;
    localparam int CNT_W  = 16;
    localparam int SPAN_W = CNT_W + 1;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5,
        MD_X6      = 3'd6,
        MD_X7      = 3'd7
    } mode_e;

    typedef struct packed {
        logic [1:0] chan;
        acc_e       acc;
        mode_e      mode;
        logic       bcd;
    } ctrl_t;

    // One step down, wrapping 0 to all-ones (binary) or all-nines (BCD)
    function automatic logic [CNT_W-1:0] dec_cnt(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic brw;
        r   = v;
        brw = 1'b1;
        if (!bcd) return v - CNT_W'(1);
        for (int i = 0; i < DIGITS; i++) begin
            if (brw) begin
                if (v[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
                else begin
                    r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
                    brw = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // Number of ticks in one full count of v; zero means the maximum
    function automatic logic [SPAN_W-1:0] span_of(input logic [CNT_W-1:0] v, input logic bcd);
        logic [SPAN_W-1:0] b;
        logic [SPAN_W-1:0] w;
        if (bcd) begin
            b = '0;
            w = SPAN_W'(1);
            for (int i = 0; i < DIGITS; i++) begin
                b = b + SPAN_W'(v[i*4 +: 4]) * w;
                w = w * SPAN_W'(10);
            end
            if (b == '0) b = w;
        end else begin
            b = {1'b0, v};
            if (b == '0) b = SPAN_W'(1) << CNT_W;
        end
        return b;
    endfunction
endpackage

// File: rtl/itm_channel.sv
module itm_channel
    import itm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cw_we,
    input  logic        latch_req,
    input  acc_e        cw_acc,
    input  mode_e       cw_mode,
    input  logic        cw_bcd,
    input  logic        data_we,
    input  logic        data_rd,
    input  logic [7:0]  din,
    input  logic        tick,
    input  logic        gate,
    output logic [7:0]  dout,
    output logic        out
);
    mode_e              mode;
    acc_e               acc;
    logic               bcd;
    logic [CNT_W-1:0]   cnt, reload, lat_val, new_val, src;
    logic [7:0]         lo_hold;
    logic               flip, latched, run, gate_q;
    logic [SPAN_W-1:0]  span, elapsed;
    logic               load_now, trig, adv, supported;

    assign supported = (mode != MD_ONESHOT) && (mode != MD_X6) && (mode != MD_X7);
    assign load_now  = data_we && (acc != ACC_WORD || flip);
    assign trig      = (mode == MD_HWSTB) && gate && !gate_q;
    assign adv       = tick && run && (mode == MD_HWSTB || gate);

    always_comb begin
        case (acc)
            ACC_LO:   new_val = {8'h00, din};
            ACC_HI:   new_val = {din, 8'h00};
            default:  new_val = {din, lo_hold};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MD_ONESHOT;
            acc     <= ACC_WORD;
            bcd     <= 1'b0;
            cnt     <= '0;
            reload  <= '0;
            lat_val <= '0;
            lo_hold <= '0;
            flip    <= 1'b0;
            latched <= 1'b0;
            run     <= 1'b0;
            span    <= SPAN_W'(1);
            elapsed <= '0;
            gate_q  <= 1'b0;
        end else begin
            gate_q <= gate;
            if (latch_req && !latched) begin
                lat_val <= cnt;
                latched <= 1'b1;
            end
            if (data_rd) begin
                if (acc != ACC_WORD || flip) latched <= 1'b0;
                if (acc == ACC_WORD) flip <= !flip;
            end
            if (data_we) begin
                if (acc == ACC_WORD) begin
                    if (!flip) lo_hold <= din;
                    flip <= !flip;
                end
            end
            if (cw_we) begin
                mode    <= cw_mode;
                acc     <= cw_acc;
                bcd     <= cw_bcd;
                flip    <= 1'b0;
                latched <= 1'b0;
                run     <= 1'b0;
                elapsed <= '0;
            end else if (load_now) begin
                cnt     <= new_val;
                reload  <= new_val;
                span    <= span_of(new_val, bcd);
                elapsed <= '0;
                run     <= supported && (mode != MD_HWSTB);
            end else if (trig) begin
                cnt     <= reload;
                elapsed <= '0;
                run     <= 1'b1;
            end else if (adv) begin
                cnt <= dec_cnt(cnt, bcd);
                case (mode)
                    MD_RATE, MD_SQUARE: begin
                        if (elapsed == span - SPAN_W'(1)) begin
                            elapsed <= '0;
                            cnt     <= reload;
                        end else elapsed <= elapsed + SPAN_W'(1);
                    end
                    MD_TERM: if (elapsed != span) elapsed <= elapsed + SPAN_W'(1);
                    default: begin
                        if (elapsed == span) begin
                            run     <= 1'b0;
                            elapsed <= '0;
                        end else elapsed <= elapsed + SPAN_W'(1);
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (mode)
            MD_TERM:            out = run && (elapsed == span);
            MD_RATE:            out = !(run && (elapsed == span - SPAN_W'(1)));
            MD_SQUARE:          out = !run || (elapsed < ((span + SPAN_W'(1)) >> 1));
            MD_SWSTB, MD_HWSTB: out = !(run && (elapsed == span));
            default:            out = 1'b1;
        endcase
    end

    assign src = latched ? lat_val : cnt;
    always_comb begin
        case (acc)
            ACC_HI:   dout = src[15:8];
            ACC_WORD: dout = flip ? src[15:8] : src[7:0];
            default:  dout = src[7:0];
        endcase
    end

    // R4: a held snapshot does not move until it is released
    a_r4_snapshot_held: assert property (@(posedge clk) disable iff (rst)
        latched |=> (!latched || $stable(lat_val)));
    // R6: BCD counting keeps every digit in 0..9 (valid BCD loads assumed)
    a_r6_bcd_digits: assert property (@(posedge clk) disable iff (rst)
        (run && bcd) |-> (cnt[3:0] <= 4'd9 && cnt[7:4] <= 4'd9 &&
                          cnt[11:8] <= 4'd9 && cnt[15:12] <= 4'd9));
    // R7: a terminal-count flag stays high until reprogrammed or reloaded
    a_r7_term_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_TERM && out && !cw_we && !load_now) |=> out);
    // R8: rate mode low pulse lasts a single tick period (counts >= 2 assumed)
    a_r8_single_low: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RATE && !out && adv && !cw_we && !load_now) |=> out);
    // R10: position within a run never passes the run length
    a_r10_span_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (elapsed <= span));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import itm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cs,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_din,
    output logic [7:0]       bus_dout,
    input  logic             cnt_tick,
    input  logic [NCH-1:0]   ch_gate,
    output logic [NCH-1:0]   ch_out
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    ctrl_t          cw;
    logic           is_ctl;
    logic [NCH-1:0] c_we, c_lat, d_we, d_rd;
    logic [7:0]     ch_dout [NCH];

    assign cw     = ctrl_t'(bus_din);
    assign is_ctl = bus_cs && bus_wr && (bus_addr == CTL_ADDR);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign c_we[i]  = is_ctl && (cw.chan == 2'(i)) && (cw.acc != ACC_LATCH);
        assign c_lat[i] = is_ctl && (cw.chan == 2'(i)) && (cw.acc == ACC_LATCH);
        assign d_we[i]  = bus_cs && bus_wr && (bus_addr == 2'(i));
        assign d_rd[i]  = bus_cs && bus_rd && (bus_addr == 2'(i));

        itm_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .cw_we     (c_we[i]),
            .latch_req (c_lat[i]),
            .cw_acc    (cw.acc),
            .cw_mode   (cw.mode),
            .cw_bcd    (cw.bcd),
            .data_we   (d_we[i]),
            .data_rd   (d_rd[i]),
            .din       (bus_din),
            .tick      (cnt_tick),
            .gate      (ch_gate[i]),
            .dout      (ch_dout[i]),
            .out       (ch_out[i])
        );
    end

    always_comb begin
        bus_dout = '0;
        for (int i = 0; i < NCH; i++) begin
            if (d_rd[i]) bus_dout = ch_dout[i];
        end
    end

    // R2: one bus write reaches at most one channel register
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(c_we | c_lat | d_we));
    // R1: nothing is driven onto the read bus without a channel read
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        (d_rd == '0) |-> (bus_dout == 8'h00));
endmodule

// File: tb/sim_tri_interval_timer.sv
`timescale 1ns/1ps
module sim_tri_interval_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 0, bus_rd = 0, bus_wr = 0, cnt_tick = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_din = 0;
    logic [7:0] bus_dout;
    logic [2:0] ch_gate = 3'b111;
    logic [2:0] ch_out;
    int nvec = 0, nbad = 0;

    always #2.5 clk = ~clk;

    tri_interval_timer u0 (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_din(bus_din), .bus_dout(bus_dout),
        .cnt_tick(cnt_tick), .ch_gate(ch_gate), .ch_out(ch_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_cs = 1; bus_wr = 1; bus_addr = a; bus_din = d;
        cyc();
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_cs = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_dout;
        cyc();
        bus_cs = 0; bus_rd = 0;
    endtask

    function automatic logic [7:0] mk(input int ch, input int acc, input int md, input int bcd);
        return {2'(ch), 2'(acc), 3'(md), 1'(bcd)};
    endfunction

    task automatic load16(input logic [1:0] ch, input logic [15:0] v);
        wr(ch, v[7:0]);
        wr(ch, v[15:8]);
    endtask

    task automatic read16(input logic [1:0] ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(ch, lo);
        rd(ch, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        cnt_tick = 1;
        repeat (n) cyc();
        cnt_tick = 0;
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    initial begin
        #(5.0 * 150000);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) cyc();
        rst = 0;
        cyc();

        // R1 reset state
        chk("R1 outputs", 16'(ch_out), 16'h7);
        chk("R1 dout", 16'(bus_dout), 16'h0);

        // R2 select value 3 is ignored (would be mode 0 -> low output)
        wr(3, mk(3, 3, 0, 0));
        chk("R2 ignored select", 16'(ch_out), 16'h7);

        // R7 mode 0 on channel 0, N=5
        wr(3, mk(0, 3, 0, 0));
        chk("R7 low after control", 16'(ch_out[0]), 16'h0);
        load16(0, 16'd5);
        cnt_tick = 1;
        for (int j = 1; j <= 7; j++) begin
            cyc();
            chk("R7 terminal", 16'(ch_out[0]), 16'(j >= 5));
        end
        cnt_tick = 0;
        chk("R2 other channels", 16'(ch_out[2:1]), 16'h3);

        // R3 count does not start until the final byte
        wr(3, mk(0, 3, 0, 0));
        wr(0, 8'h02);
        ticks(5);
        chk("R3 half-written count idle", 16'(ch_out[0]), 16'h0);
        wr(0, 8'h00);
        cnt_tick = 1;
        for (int j = 1; j <= 2; j++) begin
            cyc();
            chk("R3 count after final byte", 16'(ch_out[0]), 16'(j >= 2));
        end
        cnt_tick = 0;

        // R13 / R5 / R12 / R4 on channel 1
        wr(3, mk(1, 3, 0, 0));
        load16(1, 16'd10);
        repeat (5) cyc();
        read16(1, v);
        chk("R13 no tick no count", v, 16'd10);
        ticks(3);
        read16(1, v);
        chk("R5 live read", v, 16'd7);
        ch_gate = 3'b101;
        ticks(4);
        ch_gate = 3'b111;
        read16(1, v);
        chk("R12 gate low holds", v, 16'd7);
        wr(3, mk(1, 0, 0, 0));
        ticks(3);
        wr(3, mk(1, 0, 0, 0));
        read16(1, v);
        chk("R4 snapshot value", v, 16'd7);
        read16(1, v);
        chk("R4 live after snapshot", v, 16'd4);
        chk("R4 mode kept", 16'(ch_out[1]), 16'h0);

        // R3 low-only and high-only access on channel 2
        wr(3, mk(2, 1, 0, 0));
        wr(2, 8'h03);
        rd(2, b);
        chk("R3 low-only readback", 16'(b), 16'h03);
        cnt_tick = 1;
        for (int j = 1; j <= 3; j++) begin
            cyc();
            chk("R3 low-only count", 16'(ch_out[2]), 16'(j >= 3));
        end
        cnt_tick = 0;
        wr(3, mk(2, 2, 0, 0));
        wr(2, 8'h01);
        rd(2, b);
        chk("R3 high-only readback", 16'(b), 16'h01);
        ticks(1);
        rd(2, b);
        chk("R3 high-only after tick", 16'(b), 16'h00);

        // R8 rate sweep on channel 0
        for (int n = 2; n <= 7; n++) begin
            wr(3, mk(0, 3, 2, 0));
            load16(0, 16'(n));
            cnt_tick = 1;
            for (int j = 1; j <= 3 * n; j++) begin
                cyc();
                chk("R8 rate pulse", 16'(ch_out[0]), 16'((j % n) != n - 1));
            end
            cnt_tick = 0;
        end

        // R9 square sweep on channel 1
        for (int n = 2; n <= 9; n++) begin
            wr(3, mk(1, 3, 3, 0));
            load16(1, 16'(n));
            cnt_tick = 1;
            for (int j = 1; j <= 2 * n; j++) begin
                cyc();
                chk("R9 square duty", 16'(ch_out[1]), 16'((j % n) < (n + 1) / 2));
            end
            cnt_tick = 0;
        end

        // R10 software strobe sweep on channel 2
        for (int n = 3; n <= 5; n++) begin
            wr(3, mk(2, 3, 4, 0));
            load16(2, 16'(n));
            cnt_tick = 1;
            for (int j = 1; j <= n + 2; j++) begin
                cyc();
                chk("R10 strobe", 16'(ch_out[2]), 16'(j != n));
            end
            cnt_tick = 0;
        end

        // R11 hardware strobe on channel 2
        ch_gate = 3'b011;
        wr(3, mk(2, 3, 5, 0));
        load16(2, 16'd4);
        cnt_tick = 1;
        for (int j = 1; j <= 6; j++) begin
            cyc();
            chk("R11 idle before trigger", 16'(ch_out[2]), 16'h1);
        end
        cnt_tick = 0;
        read16(2, v);
        chk("R11 count held before trigger", v, 16'd4);
        ch_gate = 3'b111;
        cyc();
        cnt_tick = 1;
        for (int j = 1; j <= 6; j++) begin
            cyc();
            chk("R11 triggered strobe", 16'(ch_out[2]), 16'(j != 4));
        end
        cnt_tick = 0;

        // R6 zero means maximum, BCD and binary
        wr(3, mk(0, 3, 0, 1));
        load16(0, 16'h0000);
        ticks(1);
        read16(0, v);
        chk("R6 BCD zero wraps", v, 16'h9999);
        chk("R6 not yet terminal", 16'(ch_out[0]), 16'h0);
        wr(3, mk(0, 3, 0, 0));
        load16(0, 16'h0000);
        ticks(1);
        read16(0, v);
        chk("R6 binary zero wraps", v, 16'hFFFF);

        // R6 BCD decrement sweep across digit borrows
        wr(3, mk(0, 3, 0, 1));
        load16(0, to_bcd(100));
        for (int k = 1; k <= 12; k++) begin
            ticks(1);
            read16(0, v);
            chk("R6 BCD step", v, to_bcd(100 - k));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule